// File: doc/BRIEF.md
# Indexed RGB Palette RAM Port

This block is a colour lookup table with 256 entries. Each entry holds a red, a green and a blue component of 6 bits. A processor loads and inspects the table through four byte-wide registers: a write pointer, a read pointer, a data port and a pixel mask. Each access to the data port moves through the three components of the current entry. After the blue component, the entry pointer advances.

A second, independent port turns a pixel byte into an 18-bit colour. The byte is first ANDed with the mask register. The result is the entry index, and the colour appears one clock later. Both ports share one clock.

Processor register reads are registered. `cpuRdata` takes the new value on the edge that samples `cpuRd`, and it holds that value until the next read.

Top module: `pal_lut_port`

## Requirements
- R1: During and just after reset, both pointers and their component counters are 0, the mask is 0xFF, `cpuRdata` is 0 and `pixColor` is 0.
- R2: Register select codes on `cpuSel` are 0 for the write pointer, 1 for the read pointer, 2 for data and 3 for the mask. Writing code 0 sets the write entry and points the write counter at red. Reading code 0 returns the write pointer.
- R3: Three data writes store red, then green, then blue of the current write entry. The write pointer then increases by one. A write to code 0 in the middle of an entry restarts at red and leaves the components already stored in place.
- R4: Both pointers wrap modulo 256. After 256 full entries are written from entry 0, reading the write pointer returns 0.
- R5: Writing code 1 sets the read entry and points the read counter at red. Successive data reads return red, green and blue, and then the read pointer advances. Reading code 1 shows the pointer, which changes only after the blue read.
- R6: Only data bits 5:0 are stored. A data read returns 0 in bits 7:6.
- R7: The read pointer and counter are independent of the write pointer and counter. Data reads placed between the data writes of one entry do not disturb the writes.
- R8: `pixColor` equals {red, green, blue} (red in bits 17:12, blue in bits 5:0) of entry `pixIn & mask`, one clock after `pixIn` is presented. A mask of 0xFF passes the pixel unchanged.
- R9: The mask register is written and read back through code 3.
- R10: `cpuRdata` changes only on a clock edge where `cpuRd` is high. Data writes and idle cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rstN | input | 1 | Synchronous active-low reset |
| cpuSel | input | 2 | Register select |
| cpuWr | input | 1 | Register write strobe |
| cpuRd | input | 1 | Register read strobe |
| cpuWdata | input | 8 | Write data |
| cpuRdata | output | 8 | Registered read data |
| pixIn | input | 8 | Pixel byte to look up |
| pixColor | output | 18 | Colour of the masked entry, one clock later |

## Verification
The bench loads the whole table with values that have bits 7:6 set, then reads it back. A design that stores or returns those bits fails every readback, and one that wraps wrongly leaves a nonzero write pointer at the end. Reads are interleaved with the writes of one entry, which catches a design that shares a single component counter between reads and writes. A pointer write in mid-entry checks that the counter restarts at red without clobbering the components already stored. Pixel checks use a mask that is not 0xFF, sampled exactly one clock later, to expose an unmasked index or a wrong latency.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int PAL_IDX_W  = 8;
  localparam int PAL_COMP_W = 6;
  localparam int PAL_BUS_W  = 8;

  typedef enum logic [1:0] {
    SEL_WIDX = 2'd0,
    SEL_RIDX = 2'd1,
    SEL_DATA = 2'd2,
    SEL_MASK = 2'd3
  } palSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                 memWr;
    logic [1:0]           wrComp;
    logic [PAL_IDX_W-1:0] wrAddr;
    logic [1:0]           rdComp;
    logic [PAL_IDX_W-1:0] rdAddr;
    logic                 loadData;
    logic                 loadReg;
    logic [PAL_BUS_W-1:0] regVal;
  } palStb_t;
endpackage

// File: rtl/pal_ctrl.sv
module pal_ctrl
  import pal_pkg::*;
#(
  parameter int IDX_W = PAL_IDX_W,
  parameter int BUS_W = PAL_BUS_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       cpuSel,
  input  logic             cpuWr,
  input  logic             cpuRd,
  input  logic [BUS_W-1:0] cpuWdata,
  output palStb_t          stb,
  output logic [IDX_W-1:0] pixMask
);
  localparam logic [1:0] LAST_COMP = 2'd2;

  palSel_e          sel;
  logic [IDX_W-1:0] wrIdx, rdIdx, maskReg;
  logic [1:0]       wrCnt, rdCnt;
  logic             dataWr, dataRd;

  assign sel    = palSel_e'(cpuSel);
  assign dataWr = cpuWr && (sel == SEL_DATA);
  assign dataRd = cpuRd && (sel == SEL_DATA);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrIdx   <= '0;
      rdIdx   <= '0;
      wrCnt   <= '0;
      rdCnt   <= '0;
      maskReg <= '1;
    end else begin
      // read-side walk; a same-cycle pointer write below takes precedence
      if (dataRd) begin
        if (rdCnt == LAST_COMP) begin
          rdCnt <= '0;
          rdIdx <= rdIdx + 1'b1;
        end else begin
          rdCnt <= rdCnt + 1'b1;
        end
      end
      if (cpuWr) begin
        unique case (sel)
          SEL_WIDX: begin
            wrIdx <= cpuWdata[IDX_W-1:0];
            wrCnt <= '0;
          end
          SEL_RIDX: begin
            rdIdx <= cpuWdata[IDX_W-1:0];
            rdCnt <= '0;
          end
          SEL_DATA: begin
            if (wrCnt == LAST_COMP) begin
              wrCnt <= '0;
              wrIdx <= wrIdx + 1'b1;
            end else begin
              wrCnt <= wrCnt + 1'b1;
            end
          end
          SEL_MASK: maskReg <= cpuWdata[IDX_W-1:0];
          default: ;
        endcase
      end
    end
  end

  logic [BUS_W-1:0] regMux;
  always_comb begin
    regMux = '0;
    unique case (sel)
      SEL_WIDX: regMux[IDX_W-1:0] = wrIdx;
      SEL_RIDX: regMux[IDX_W-1:0] = rdIdx;
      SEL_MASK: regMux[IDX_W-1:0] = maskReg;
      default:  regMux = '0;
    endcase
  end

  always_comb begin
    stb.memWr    = dataWr;
    stb.wrComp   = wrCnt;
    stb.wrAddr   = wrIdx;
    stb.rdComp   = rdCnt;
    stb.rdAddr   = rdIdx;
    stb.loadData = dataRd;
    stb.loadReg  = cpuRd && (sel != SEL_DATA);
    stb.regVal   = regMux;
  end

  assign pixMask = maskReg;
endmodule

// File: rtl/pal_datapath.sv
module pal_datapath
  import pal_pkg::*;
#(
  parameter int IDX_W  = PAL_IDX_W,
  parameter int COMP_W = PAL_COMP_W,
  parameter int BUS_W  = PAL_BUS_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  palStb_t             stb,
  input  logic [BUS_W-1:0]    cpuWdata,
  input  logic [IDX_W-1:0]    pixIn,
  input  logic [IDX_W-1:0]    pixMask,
  output logic [BUS_W-1:0]    cpuRdata,
  output logic [3*COMP_W-1:0] pixColor
);
  localparam int DEPTH  = 1 << IDX_W;
  localparam int NCOMP  = 3;
  localparam int PAD_W  = BUS_W - COMP_W;

  logic [COMP_W-1:0] cpuComp [NCOMP];
  logic [COMP_W-1:0] pixComp [NCOMP];
  logic [IDX_W-1:0]  pixAddr;

  assign pixAddr = pixIn & pixMask;

  // one storage array per component; red is component 0
  for (genvar c = 0; c < NCOMP; c++) begin : g_comp
    logic [COMP_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (stb.memWr && (stb.wrComp == 2'(c)))
        mem[stb.wrAddr] <= cpuWdata[COMP_W-1:0];
    end

    assign cpuComp[c] = mem[stb.rdAddr];
    assign pixComp[NCOMP-1-c] = mem[pixAddr];
  end

  logic [COMP_W-1:0] cpuSelComp;
  always_comb begin
    unique case (stb.rdComp)
      2'd0:    cpuSelComp = cpuComp[0];
      2'd1:    cpuSelComp = cpuComp[1];
      default: cpuSelComp = cpuComp[2];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuRdata <= '0;
      pixColor <= '0;
    end else begin
      if (stb.loadData)
        cpuRdata <= {{PAD_W{1'b0}}, cpuSelComp};
      else if (stb.loadReg)
        cpuRdata <= stb.regVal;
      pixColor <= {pixComp[2], pixComp[1], pixComp[0]};
    end
  end
endmodule

// File: rtl/pal_lut_port.sv
module pal_lut_port
  import pal_pkg::*;
#(
  parameter int IDX_W  = PAL_IDX_W,
  parameter int COMP_W = PAL_COMP_W,
  parameter int BUS_W  = PAL_BUS_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          cpuSel,
  input  logic                cpuWr,
  input  logic                cpuRd,
  input  logic [BUS_W-1:0]    cpuWdata,
  output logic [BUS_W-1:0]    cpuRdata,
  input  logic [IDX_W-1:0]    pixIn,
  output logic [3*COMP_W-1:0] pixColor
);
  palStb_t          stb;
  logic [IDX_W-1:0] pixMask;

  pal_ctrl #(.IDX_W(IDX_W), .BUS_W(BUS_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWr(cpuWr), .cpuRd(cpuRd),
    .cpuWdata(cpuWdata), .stb(stb), .pixMask(pixMask)
  );

  pal_datapath #(.IDX_W(IDX_W), .COMP_W(COMP_W), .BUS_W(BUS_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cpuWdata(cpuWdata), .pixIn(pixIn),
    .pixMask(pixMask), .cpuRdata(cpuRdata), .pixColor(pixColor)
  );
endmodule

// File: rtl/pal_lut_port_chk.sv
module pal_lut_port_chk #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 6,
  parameter int BUS_W  = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [1:0]          cpuSel,
  input logic                cpuWr,
  input logic                cpuRd,
  input logic [BUS_W-1:0]    cpuWdata,
  input logic [BUS_W-1:0]    cpuRdata,
  input logic [IDX_W-1:0]    pixIn,
  input logic [3*COMP_W-1:0] pixColor
);
  // R10: no read strobe, no change on the read bus
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !cpuRd |=> $stable(cpuRdata));

  // R6: data reads carry zeros above the stored component
  p_data_pad_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRd && cpuSel == 2'd2) |=> (cpuRdata[BUS_W-1:COMP_W] == '0));

  // R2: a write-pointer load is visible on the next read of that register
  p_wptr_readback_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && cpuSel == 2'd0) ##1 (cpuRd && !cpuWr && cpuSel == 2'd0)
      |=> (cpuRdata[IDX_W-1:0] == $past(cpuWdata[IDX_W-1:0], 2)));

  // R9: a mask load is visible on the next read of that register
  p_mask_readback_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && cpuSel == 2'd3) ##1 (cpuRd && !cpuWr && cpuSel == 2'd3)
      |=> (cpuRdata[IDX_W-1:0] == $past(cpuWdata[IDX_W-1:0], 2)));

  // R8: same pixel, no table or mask update -> same colour
  p_pix_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(cpuWr) && pixIn == $past(pixIn)) |=> $stable(pixColor));
endmodule

bind pal_lut_port pal_lut_port_chk #(.IDX_W(IDX_W), .COMP_W(COMP_W), .BUS_W(BUS_W)) u_chk (.*);

// File: tb/sim_pal_lut_port.sv
`timescale 1ns/1ps
module sim_pal_lut_port;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  cpuSel = 2'd0;
  logic        cpuWr = 1'b0;
  logic        cpuRd = 1'b0;
  logic [7:0]  cpuWdata = 8'd0;
  logic [7:0]  cpuRdata;
  logic [7:0]  pixIn = 8'd0;
  logic [17:0] pixColor;

  int nChecks = 0;
  int nFails  = 0;

  logic [5:0] refR [256];
  logic [5:0] refG [256];
  logic [5:0] refB [256];

  always #10 clk = ~clk;

  pal_lut_port u0 (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWr(cpuWr), .cpuRd(cpuRd),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .pixIn(pixIn), .pixColor(pixColor)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] sel, input logic [7:0] val);
    @(negedge clk);
    cpuSel = sel; cpuWdata = val; cpuWr = 1'b1;
    @(negedge clk);
    cpuWr = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] sel, output logic [7:0] val);
    @(negedge clk);
    cpuSel = sel; cpuRd = 1'b1;
    @(negedge clk);
    cpuRd = 1'b0;
    val = cpuRdata;
  endtask

  task automatic pixLook(input logic [7:0] p, output logic [17:0] col);
    @(negedge clk);
    pixIn = p;
    @(negedge clk);
    col = pixColor;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 pixColor in reset", int'(pixColor), 0);
    check("R1 cpuRdata in reset", int'(cpuRdata), 0);
    @(negedge clk);
    rstN = 1'b1;
    rdReg(2'd0, v); check("R1 write pointer", v, 0);
    rdReg(2'd1, v); check("R1 read pointer", v, 0);
    rdReg(2'd3, v); check("R1 mask 0xFF", v, 8'hFF);
  endtask

  task automatic t_fill();
    logic [7:0] v;
    int bad = 0;
    wrReg(2'd0, 8'd0);
    for (int i = 0; i < 256; i++) begin
      refR[i] = 6'(i); refG[i] = 6'(i * 3); refB[i] = 6'(~i);
      wrReg(2'd2, {2'b11, refR[i]});
      wrReg(2'd2, {2'b10, refG[i]});
      wrReg(2'd2, {2'b01, refB[i]});
    end
    rdReg(2'd0, v); check("R4 write pointer wraps to 0", v, 0);
    wrReg(2'd1, 8'd0);
    for (int i = 0; i < 256; i++) begin
      rdReg(2'd2, v); if (v != {2'b00, refR[i]}) bad++;
      check("R6 R3 red readback", v, {2'b00, refR[i]});
      rdReg(2'd2, v); check("R6 R3 green readback", v, {2'b00, refG[i]});
      rdReg(2'd2, v); check("R6 R3 blue readback", v, {2'b00, refB[i]});
    end
    rdReg(2'd1, v); check("R4 read pointer wraps to 0", v, 0);
  endtask

  task automatic t_restart();
    logic [7:0] v;
    wrReg(2'd0, 8'd5);
    wrReg(2'd2, 8'h11); wrReg(2'd2, 8'h22);
    refR[5] = 6'h11; refG[5] = 6'h22;
    wrReg(2'd0, 8'd9);
    rdReg(2'd0, v); check("R2 write pointer load", v, 9);
    wrReg(2'd2, 8'h01); wrReg(2'd2, 8'h02); wrReg(2'd2, 8'h03);
    refR[9] = 6'h01; refG[9] = 6'h02; refB[9] = 6'h03;
    rdReg(2'd0, v); check("R3 pointer advance after blue", v, 10);
    wrReg(2'd1, 8'd5);
    rdReg(2'd2, v); check("R3 partial red kept", v, refR[5]);
    rdReg(2'd1, v); check("R5 read pointer unchanged mid-entry", v, 5);
    rdReg(2'd2, v); check("R3 partial green kept", v, refG[5]);
    rdReg(2'd2, v); check("R3 blue untouched", v, refB[5]);
    rdReg(2'd1, v); check("R5 read pointer after blue", v, 6);
    wrReg(2'd1, 8'd9);
    rdReg(2'd2, v); check("R2 restart red", v, 8'h01);
    rdReg(2'd2, v); check("R2 restart green", v, 8'h02);
    rdReg(2'd2, v); check("R2 restart blue", v, 8'h03);
  endtask

  task automatic t_interleave();
    logic [7:0] v;
    wrReg(2'd0, 8'd20);
    wrReg(2'd1, 8'd40);
    wrReg(2'd2, 8'h2A);
    rdReg(2'd2, v); check("R7 read red between writes", v, refR[40]);
    wrReg(2'd2, 8'h15);
    rdReg(2'd2, v); check("R7 read green between writes", v, refG[40]);
    wrReg(2'd2, 8'h3F);
    rdReg(2'd2, v); check("R7 read blue between writes", v, refB[40]);
    refR[20] = 6'h2A; refG[20] = 6'h15; refB[20] = 6'h3F;
    rdReg(2'd0, v); check("R7 write pointer", v, 21);
    rdReg(2'd1, v); check("R7 read pointer", v, 41);
    wrReg(2'd1, 8'd20);
    rdReg(2'd2, v); check("R7 stored red", v, 8'h2A);
    rdReg(2'd2, v); check("R7 stored green", v, 8'h15);
    rdReg(2'd2, v); check("R7 stored blue", v, 8'h3F);
  endtask

  task automatic t_pixel();
    logic [17:0] col;
    logic [7:0] v;
    pixLook(8'd7, col);
    check("R8 mask FF lookup", col, {refR[7], refG[7], refB[7]});
    pixLook(8'd200, col);
    check("R8 mask FF high entry", col, {refR[200], refG[200], refB[200]});
    wrReg(2'd3, 8'h0F);
    rdReg(2'd3, v); check("R9 mask readback", v, 8'h0F);
    pixLook(8'hF7, col);
    check("R8 masked lookup", col, {refR[7], refG[7], refB[7]});
    pixLook(8'hA4, col);
    check("R8 masked lookup 2", col, {refR[4], refG[4], refB[4]});
    wrReg(2'd3, 8'hFF);
    pixLook(8'd20, col);
    check("R8 colour order", col, {6'h2A, 6'h15, 6'h3F});
  endtask

  task automatic t_hold();
    logic [7:0] v;
    wrReg(2'd1, 8'd20);
    rdReg(2'd2, v);
    check("R10 read value", v, 8'h2A);
    repeat (3) @(negedge clk);
    check("R10 hold on idle", int'(cpuRdata), 8'h2A);
    wrReg(2'd0, 8'd100);
    wrReg(2'd2, 8'h07);
    check("R10 hold on writes", int'(cpuRdata), 8'h2A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_fill();
    t_restart();
    t_interleave();
    t_pixel();
    t_hold();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule